// File: doc/BRIEF.md
# Far-End Fault Pattern Generator and Detector

This block carries a remote fault indication in-band on a 125 Mbps serial link whose bits are already NRZI-decoded. No auto-negotiation exists on this link type. On the transmit side, the block normally sends a steady run of ones as the idle stream. When any local fault cause is present, it swaps the idle stream for a repeating pattern: 84 ones, then one zero, for a period of 85 bits. It sends the pattern at least three times and keeps sending it for as long as a cause remains. On the receive side, it counts ones between zeros in the incoming bit stream. It raises a far-end-fault flag for a link monitor once three correctly spaced patterns arrive back to back.

Bits move one per clock in which the bit enable `bit_en` is high. Both serial directions are paced only by this strobe. Neither direction can stall the other, so there is no back-pressure. The transmit bit is defined in every cycle. The link consumes it, and the receive bit is taken, only in a cycle where `bit_en` is high. Cause inputs and the status outputs are plain levels.

Top module: `fef_link_signal`

## Requirements
- R1: While the transmitter is not sending the fault pattern, every transmitted bit is a logic one. This is the idle stream.
- R2: Every zero the transmitter sends follows at least 84 consecutive transmitted ones. Inside a fault burst, the zeros are exactly 85 bits apart.
- R3: Each of the four causes is enough on its own to start the pattern: signal loss, lock loss, no activity from the partner, and the management force bit. If a cause is high on a strobed bit while the transmitter is idle, that bit is the first one of the pattern, and `tx_fault_active` is high from the next cycle.
- R4: Once started, a burst holds at least 3 complete patterns, even if the cause lasted only a single bit.
- R5: The pattern repeats while any cause is high. The transmitter returns to idle only at a pattern boundary, in the cycle after a zero was sent, so it never sends a truncated pattern.
- R6: A received zero counts as a valid pattern end when at least 84 ones came directly before it. `far_fault` rises in the cycle after the third consecutive valid pattern end.
- R7: While valid pattern ends keep arriving, `far_fault` stays high.
- R8: A received zero that comes after fewer than 84 ones is treated as carrier. It clears the pattern count and `far_fault`, so three fresh valid patterns are needed again.
- R9: A run of 85 received ones clears the pattern count and `far_fault`.
- R10: In a cycle where `bit_en` is low, no state changes, and all outputs hold their values at the next edge.
- R11: After reset, `tx_bit` is 1 and both `tx_fault_active` and `far_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe; one serial bit moves per cycle in which it is high |
| rx_bit | input | 1 | Decoded receive bit |
| sig_loss | input | 1 | Fault cause: no receive signal |
| lock_loss | input | 1 | Fault cause: clock recovery not locked |
| no_activity | input | 1 | Fault cause: nothing received from the partner |
| mgmt_force | input | 1 | Fault cause: management request to send the fault pattern |
| tx_bit | output | 1 | Transmit bit, either idle ones or the fault pattern |
| tx_fault_active | output | 1 | High while a fault burst is in progress |
| far_fault | output | 1 | The partner is signalling a far-end fault |

## Verification
On the transmit side, the bench uses a one-bit cause pulse and a cause held across several periods that drops mid-pattern. The pulse tells the three-pattern minimum apart from simply following the cause. The long cause tells boundary-aligned stopping apart from stopping at once. Each cause is also tried alone, which shows that all four feed the start condition. On the receive side, the bench sends clean back-to-back patterns (detection and holding), an 85-one gap (timeout clearing), and a zero after 40 ones in the middle of a sequence (the carrier reset of the count). A stretch with a sparse strobe shows that every state change follows `bit_en` and not the clock.

// File: rtl/fef_pkg.sv
package fef_pkg;
  // Number of fault causes gathered at the top
  localparam int unsigned NUM_CAUSES = 4;

  // Saturating increment bounded by a limit
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  typedef enum logic { TX_IDLE = 1'b0, TX_BURST = 1'b1 } tx_mode_e;
endpackage

// File: rtl/fef_cause_merge.sv
module fef_cause_merge #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] causes,
  output logic         any_cause
);
  logic [N:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_or
    assign chain[i+1] = chain[i] | causes[i];
  end
  assign any_cause = chain[N];
endmodule

// File: rtl/fef_tx_gen.sv
module fef_tx_gen
  import fef_pkg::*;
#(
  parameter int unsigned ONES_LEN = 84,
  parameter int unsigned MIN_REPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic fault_req,
  output logic tx_bit,
  output logic sending
);
  localparam int unsigned PERIOD = ONES_LEN + 1;
  localparam int unsigned PH_W   = $clog2(PERIOD);
  localparam int unsigned REP_W  = $clog2(MIN_REPS + 1);

  tx_mode_e          mode_q, mode_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [REP_W-1:0]  reps_q, reps_d;
  logic              at_zero;
  logic [REP_W-1:0]  reps_inc;

  assign at_zero  = (mode_q == TX_BURST) && (phase_q == PH_W'(ONES_LEN));
  assign reps_inc = REP_W'(sat_inc(int'(reps_q), MIN_REPS));

  always_comb begin
    mode_d  = mode_q;
    phase_d = phase_q;
    reps_d  = reps_q;
    if (bit_en) begin
      if (mode_q == TX_IDLE) begin
        if (fault_req) begin
          // the idle one sent on this bit doubles as the first pattern bit
          mode_d  = TX_BURST;
          phase_d = PH_W'(1);
          reps_d  = '0;
        end
      end else if (at_zero) begin
        phase_d = '0;
        reps_d  = reps_inc;
        if (!fault_req && (reps_inc >= REP_W'(MIN_REPS))) begin
          mode_d = TX_IDLE;
        end
      end else begin
        phase_d = phase_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= TX_IDLE;
      phase_q <= '0;
      reps_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      phase_q <= phase_d;
      reps_q  <= reps_d;
    end
  end

  assign tx_bit  = !at_zero;
  assign sending = (mode_q == TX_BURST);
endmodule

// File: rtl/fef_rx_det.sv
module fef_rx_det
  import fef_pkg::*;
#(
  parameter int unsigned ONES_LEN    = 84,
  parameter int unsigned DETECT_REPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output logic far_fault
);
  localparam int unsigned RUN_MAX = ONES_LEN + 1;
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);
  localparam int unsigned CNT_W   = $clog2(DETECT_REPS + 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             good_end;
  logic [CNT_W-1:0] cnt_inc;

  assign good_end = (run_q >= RUN_W'(ONES_LEN));
  assign cnt_inc  = CNT_W'(sat_inc(int'(cnt_q), DETECT_REPS));

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (bit_en) begin
      if (rx_bit) begin
        run_d = RUN_W'(sat_inc(int'(run_q), RUN_MAX));
        if (run_d == RUN_W'(RUN_MAX)) begin
          // a whole period with no pattern end: drop the indication
          cnt_d  = '0;
          flag_d = 1'b0;
        end
      end else begin
        run_d = '0;
        if (good_end) begin
          cnt_d = cnt_inc;
          if (cnt_inc == CNT_W'(DETECT_REPS)) flag_d = 1'b1;
        end else begin
          // early zero: frame carrier, not a fault pattern
          cnt_d  = '0;
          flag_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign far_fault = flag_q;
endmodule

// File: rtl/fef_link_signal.sv
module fef_link_signal
  import fef_pkg::*;
#(
  parameter int unsigned ONES_LEN    = 84,
  parameter int unsigned MIN_REPS    = 3,
  parameter int unsigned DETECT_REPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic sig_loss,
  input  logic lock_loss,
  input  logic no_activity,
  input  logic mgmt_force,
  output logic tx_bit,
  output logic tx_fault_active,
  output logic far_fault
);
  logic [NUM_CAUSES-1:0] causes;
  logic                  fault_req;

  assign causes = {mgmt_force, no_activity, lock_loss, sig_loss};

  fef_cause_merge #(.N(NUM_CAUSES)) u_merge (
    .causes    (causes),
    .any_cause (fault_req)
  );

  fef_tx_gen #(.ONES_LEN(ONES_LEN), .MIN_REPS(MIN_REPS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .fault_req (fault_req),
    .tx_bit    (tx_bit),
    .sending   (tx_fault_active)
  );

  fef_rx_det #(.ONES_LEN(ONES_LEN), .DETECT_REPS(DETECT_REPS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .far_fault (far_fault)
  );
endmodule

// File: rtl/fef_link_checker.sv
module fef_link_checker #(
  parameter int unsigned ONES_LEN = 84,
  parameter int unsigned MIN_REPS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic rx_bit,
  input logic tx_bit,
  input logic tx_fault_active,
  input logic far_fault
);
  localparam int unsigned OW = $clog2(ONES_LEN + 1);
  localparam int unsigned ZW = $clog2(MIN_REPS + 1);

  logic [OW-1:0] tx_ones, rx_ones;
  logic [ZW-1:0] burst_zeros;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ones     <= '0;
      rx_ones     <= '0;
      burst_zeros <= '0;
    end else begin
      if (bit_en) begin
        tx_ones <= !tx_bit ? '0 : (tx_ones >= OW'(ONES_LEN)) ? tx_ones : tx_ones + OW'(1);
        rx_ones <= !rx_bit ? '0 : (rx_ones >= OW'(ONES_LEN)) ? rx_ones : rx_ones + OW'(1);
      end
      if (!tx_fault_active) burst_zeros <= '0;
      else if (bit_en && !tx_bit && burst_zeros < ZW'(MIN_REPS)) burst_zeros <= burst_zeros + ZW'(1);
    end
  end

  p_idle_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !tx_fault_active) |-> tx_bit);

  p_zero_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !tx_bit) |-> (tx_ones >= OW'(ONES_LEN)));

  p_min_reps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_fault_active) |-> (burst_zeros >= ZW'(MIN_REPS)));

  p_stop_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_fault_active) |-> $past(bit_en && !tx_bit));

  p_flag_on_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(far_fault) |-> $past(bit_en && !rx_bit));

  p_early_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !rx_bit && rx_ones < OW'(ONES_LEN)) |=> !far_fault);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(tx_bit) && $stable(tx_fault_active) && $stable(far_fault)));
endmodule

bind fef_link_signal fef_link_checker #(.ONES_LEN(ONES_LEN), .MIN_REPS(MIN_REPS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bit_en          (bit_en),
  .rx_bit          (rx_bit),
  .tx_bit          (tx_bit),
  .tx_fault_active (tx_fault_active),
  .far_fault       (far_fault)
);

// File: tb/tb_fef_link_signal.sv
module tb_fef_link_signal;
  logic clk = 1'b0;
  logic rst_n, bit_en, rx_bit, sig_loss, lock_loss, no_activity, mgmt_force;
  logic tx_bit, tx_fault_active, far_fault;

  always #10 clk = ~clk;

  fef_link_signal dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .sig_loss(sig_loss), .lock_loss(lock_loss), .no_activity(no_activity),
    .mgmt_force(mgmt_force), .tx_bit(tx_bit), .tx_fault_active(tx_fault_active),
    .far_fault(far_fault)
  );

  int tests = 0, fails = 0, tx_zeros = 0;
  string cur_req = "R11";
  bit done = 0;

  // behavioural reference state
  int m_act = 0, m_ph = 0, m_reps = 0;
  int m_run = 0, m_cnt = 0, m_flag = 0;

  task automatic check(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_tx();
    return (m_act == 1 && m_ph == 84) ? 0 : 1;
  endfunction

  task automatic model_step();
    int any;
    any = (sig_loss | lock_loss | no_activity | mgmt_force) ? 1 : 0;
    if (!bit_en) return;
    if (m_act == 0) begin
      if (any == 1) begin m_act = 1; m_ph = 1; m_reps = 0; end
    end else if (m_ph == 84) begin
      m_ph = 0;
      m_reps = (m_reps < 3) ? m_reps + 1 : 3;
      if (any == 0 && m_reps >= 3) m_act = 0;
    end else m_ph++;
    if (rx_bit) begin
      if (m_run < 85) m_run++;
      if (m_run == 85) begin m_cnt = 0; m_flag = 0; end
    end else begin
      if (m_run >= 84) begin
        m_cnt = (m_cnt < 3) ? m_cnt + 1 : 3;
        if (m_cnt == 3) m_flag = 1;
      end else begin m_cnt = 0; m_flag = 0; end
      m_run = 0;
    end
  endtask

  // compare at the falling edge, then drive and advance the model
  task automatic tick(input logic rb, input logic en);
    check(cur_req, int'(tx_bit), exp_tx(), "tx_bit");
    check(cur_req, int'(tx_fault_active), m_act, "tx_fault_active");
    check(cur_req, int'(far_fault), m_flag, "far_fault");
    if (bit_en && !tx_bit) tx_zeros++;
    rx_bit = rb;
    bit_en = en;
    model_step();
    @(negedge clk);
  endtask

  task automatic rx_ones(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b1);
  endtask

  task automatic rx_pattern(input int n);
    for (int i = 0; i < n; i++) begin rx_ones(84); tick(1'b0, 1'b1); end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bit_en = 0; rx_bit = 1;
    sig_loss = 0; lock_loss = 0; no_activity = 0; mgmt_force = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    check("R11", int'(tx_bit), 1, "tx_bit after reset");
    check("R11", int'(tx_fault_active), 0, "tx_fault_active after reset");
    check("R11", int'(far_fault), 0, "far_fault after reset");

    cur_req = "R1";
    rx_ones(200);

    // R4: one-bit cause pulse still yields three patterns
    cur_req = "R4";
    tx_zeros = 0;
    mgmt_force = 1; tick(1'b1, 1'b1); mgmt_force = 0;
    check("R3", int'(tx_fault_active), 1, "active after management force");
    rx_ones(400);
    check("R4", tx_zeros, 3, "zeros in minimum burst");
    check("R5", int'(tx_fault_active), 0, "idle after minimum burst");

    // R3: each other cause alone
    cur_req = "R3";
    sig_loss = 1; tick(1'b1, 1'b1); sig_loss = 0;
    check("R3", int'(tx_fault_active), 1, "active after signal loss");
    rx_ones(300);
    lock_loss = 1; tick(1'b1, 1'b1); lock_loss = 0;
    check("R3", int'(tx_fault_active), 1, "active after lock loss");
    rx_ones(300);
    no_activity = 1; tick(1'b1, 1'b1); no_activity = 0;
    check("R3", int'(tx_fault_active), 1, "active after no activity");
    rx_ones(300);

    // R5/R2: long cause dropping mid-pattern
    cur_req = "R5";
    tx_zeros = 0;
    sig_loss = 1;
    rx_ones(5 * 85 + 40);
    sig_loss = 0;
    rx_ones(200);
    check("R5", tx_zeros, 6, "zeros in long burst");
    check("R2", int'(tx_bit), 1, "idle bit after burst");

    // R6/R7 detection and hold
    cur_req = "R6";
    rx_ones(100);
    rx_pattern(2);
    check("R6", int'(far_fault), 0, "flag after two patterns");
    rx_pattern(1);
    check("R6", int'(far_fault), 1, "flag after third pattern");
    cur_req = "R7";
    rx_pattern(2);
    check("R7", int'(far_fault), 1, "flag held by patterns");

    // R9 timeout
    cur_req = "R9";
    rx_ones(85);
    check("R9", int'(far_fault), 0, "flag after 85 ones");

    // R8 early zero resets the count
    cur_req = "R8";
    rx_pattern(2);
    rx_ones(40); tick(1'b0, 1'b1);
    rx_pattern(2);
    check("R8", int'(far_fault), 0, "flag after early zero then two patterns");
    rx_pattern(1);
    check("R6", int'(far_fault), 1, "flag after three fresh patterns");
    rx_ones(10); tick(1'b0, 1'b1);
    check("R8", int'(far_fault), 0, "flag cleared by carrier zero");

    // R10 sparse strobe during transmit and receive activity
    cur_req = "R10";
    no_activity = 1;
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 85; i++) begin
        tick((i == 84) ? 1'b0 : 1'b1, 1'b1);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
      end
    end
    check("R10", int'(far_fault), 1, "flag with gapped strobe");
    no_activity = 0;
    for (int i = 0; i < 600; i++) tick(1'b1, (i % 2 == 0) ? 1'b1 : 1'b0);
    check("R10", int'(tx_fault_active), 0, "idle after gapped burst");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule